// File: doc/BRIEF.md
# Register Rename Map with Branch Checkpoints

This block performs explicit register renaming for a two-wide front end. A map table records which physical register currently holds each architectural register. The physical register file is larger than the architectural one, and a free vector marks the physical registers that no instruction holds. Each cycle, up to two instructions present their source and destination names. Sources are translated to physical names. Each writing instruction receives a fresh physical register, and the block returns the register that was previously mapped to its destination. That register is handed back through the commit port once the writer retires.

A group may ask for a checkpoint. The block then saves the map table as it stands after the group, together with an empty "allocated since" mask, in the next checkpoint slot, and reports the slot number as the tag. Every later allocation is recorded in the mask of every live checkpoint. When the branch resolves correctly, its slot is released. On a mispredict, the map is restored from the slot. The restored free vector is the current one ORed with the slot's mask. This returns the wrong-path registers and keeps the registers that commits freed after the checkpoint. The mispredicted slot and every younger slot are discarded.

A two-state machine controls acceptance. RUN accepts rename groups. A mispredict in any state moves the machine to RECOVER. RECOVER blocks renaming for exactly one cycle and then returns to RUN, unless a further mispredict arrives, in which case it stays in RECOVER.

Top module: `rn_rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i. Physical registers NARCH to NPHYS-1 are free.
- R2: A source name is translated to the physical register most recently assigned to that architectural register by an accepted group.
- R3: Each destination takes the lowest-numbered free physical register, which differs from the previously mapped register. The previously mapped register is reported on `rn_pold`. Slot 0 is served before slot 1.
- R4: In a two-instruction group, when a slot 1 source names slot 0's destination, it receives slot 0's new register. When both slots write the same architectural register, slot 1's `rn_pold` is slot 0's new register. The two new registers are distinct, and slot 1's mapping wins.
- R5: A register returned on the commit port becomes free on the next clock edge and can be allocated again.
- R6: A group is refused (`rn_ready` low, no state change) when the free vector holds fewer registers than the group's writing slots need.
- R7: A group with `rn_ckpt` set receives tag 0, 1, 2, ... in circular order (tag = slot number). A group asking for a checkpoint is refused while the next slot is still live.
- R8: A mispredict on tag k restores the map to its state after the group that took k.
- R9: After a mispredict on tag k, every register allocated since k is free again, and every register freed by commit since k stays free.
- R10: A group is refused in the mispredict cycle and in the following cycle (RUN to RECOVER to RUN).
- R11: A mispredict on tag k discards k and all younger checkpoints. The next checkpoint receives tag k.
- R12: A correct resolution on tag k releases slot k for reuse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rn_valid | input | 2 | Slot valid bits (slot 1 only with slot 0) |
| rn_src_a | input | 2*AW | First source name per slot, slot 0 in the low bits |
| rn_src_b | input | 2*AW | Second source name per slot |
| rn_dst_en | input | 2 | Slot writes a destination |
| rn_dst | input | 2*AW | Destination name per slot |
| rn_ckpt | input | 1 | Take a checkpoint after this group |
| rn_ready | output | 1 | Group accepted this cycle |
| rn_ps_a | output | 2*PW | Translated first sources |
| rn_ps_b | output | 2*PW | Translated second sources |
| rn_pd | output | 2*PW | New destination registers |
| rn_pold | output | 2*PW | Previously mapped destination registers |
| rn_tag | output | CW | Checkpoint tag of this group |
| cm_valid | input | 1 | Commit returns a register |
| cm_preg | input | PW | Register to return |
| br_ok_valid | input | 1 | Branch resolved correctly |
| br_ok_id | input | CW | Its tag |
| br_bad_valid | input | 1 | Branch mispredicted |
| br_bad_id | input | CW | Its tag |

## Verification
The hardest situation to reach is a mispredict whose merge must combine three things. The checkpoint must have seen allocations after it was taken, a commit must have freed a register in that same window, and the checkpoint ring must have wrapped so that younger slots lie on both sides of the mispredicted one. The stimulus fills all four slots, releases the oldest one so the ring wraps, then mispredicts a slot in the middle. Before and after these events, allocations and commits are mixed, and a lowest-first allocation order makes every returned register visible at the `rn_pd` port. A long run of single allocations then drains the free vector to reach the refusal, and commits are used to recover from it.

// File: rtl/rn_pkg.sv
package rn_pkg;
    typedef enum logic {ST_RUN, ST_RECOVER} rn_state_e;
endpackage

// File: rtl/rn_freelist.sv
module rn_freelist #(
    parameter int NARCH = 32,
    parameter int NPHYS = 64,
    localparam int PW = $clog2(NPHYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take0,
    input  logic             take1,
    input  logic             rel_valid,
    input  logic [PW-1:0]    rel_reg,
    input  logic             restore,
    input  logic [NPHYS-1:0] restore_mask,
    output logic [PW-1:0]    pick0,
    output logic [PW-1:0]    pick1,
    output logic [PW:0]      free_cnt,
    output logic [NPHYS-1:0] alloc_bits
);
    logic [NPHYS-1:0] free_q, free_d, rel_bit;

    // lowest two free registers and the population count
    always_comb begin
        logic f0, f1;
        f0 = 1'b0;
        f1 = 1'b0;
        pick0 = '0;
        pick1 = '0;
        free_cnt = '0;
        for (int i = 0; i < NPHYS; i++) begin
            free_cnt = free_cnt + (PW+1)'(free_q[i]);
            if (free_q[i]) begin
                if (!f0) begin
                    pick0 = PW'(i);
                    f0 = 1'b1;
                end else if (!f1) begin
                    pick1 = PW'(i);
                    f1 = 1'b1;
                end
            end
        end
    end

    always_comb begin
        rel_bit    = rel_valid ? (NPHYS'(1) << rel_reg) : '0;
        alloc_bits = (take0 ? (NPHYS'(1) << pick0) : '0) |
                     (take1 ? (NPHYS'(1) << pick1) : '0);
        free_d     = restore ? (free_q | restore_mask | rel_bit)
                             : ((free_q & ~alloc_bits) | rel_bit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NPHYS; i++) free_q[i] <= (i >= NARCH);
        end else begin
            free_q <= free_d;
        end
    end
endmodule

// File: rtl/rn_map.sv
module rn_map #(
    parameter int NARCH = 32,
    parameter int NPHYS = 64,
    localparam int AW = $clog2(NARCH),
    localparam int PW = $clog2(NPHYS),
    localparam int MW = NARCH * PW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we0,
    input  logic [AW-1:0] wa0,
    input  logic [PW-1:0] wd0,
    input  logic          we1,
    input  logic [AW-1:0] wa1,
    input  logic [PW-1:0] wd1,
    input  logic          restore,
    input  logic [MW-1:0] restore_map,
    output logic [MW-1:0] map_cur,
    output logic [MW-1:0] map_nxt
);
    logic [MW-1:0] map_q;

    assign map_cur = map_q;

    // slot 1 is written last so its mapping wins
    always_comb begin
        map_nxt = map_q;
        if (we0) map_nxt[wa0*PW +: PW] = wd0;
        if (we1) map_nxt[wa1*PW +: PW] = wd1;
        if (restore) map_nxt = restore_map;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NARCH; i++) map_q[i*PW +: PW] <= PW'(i);
        end else begin
            map_q <= map_nxt;
        end
    end
endmodule

// File: rtl/rn_ckpt.sv
module rn_ckpt #(
    parameter int NARCH = 32,
    parameter int NPHYS = 64,
    parameter int NCKPT = 4,
    localparam int PW = $clog2(NPHYS),
    localparam int CW = $clog2(NCKPT),
    localparam int MW = NARCH * PW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [MW-1:0]    snap_in,
    input  logic [NPHYS-1:0] alloc_bits,
    input  logic             ok_valid,
    input  logic [CW-1:0]    ok_id,
    input  logic             bad_valid,
    input  logic [CW-1:0]    bad_id,
    output logic             full,
    output logic [CW-1:0]    tail,
    output logic [MW-1:0]    back_map,
    output logic [NPHYS-1:0] back_mask
);
    logic [CW-1:0]    tail_q;
    logic [NCKPT-1:0] vld_w;
    logic [NPHYS-1:0] msk_w [NCKPT];
    logic [MW-1:0]    snp_w [NCKPT];
    logic [CW-1:0]    dist_t;

    assign dist_t = tail_q - bad_id;

    for (genvar j = 0; j < NCKPT; j++) begin : g_slot
        logic             vld;
        logic [NPHYS-1:0] msk;
        logic [MW-1:0]    snp;
        logic [CW-1:0]    dist_j;
        logic             kill, hit;

        assign dist_j = CW'(j) - bad_id;
        // slots from bad_id up to the tail are the same age or younger
        assign kill   = bad_valid && ((dist_t == '0) || (dist_j < dist_t));
        assign hit    = take && (tail_q == CW'(j));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld <= 1'b0;
                msk <= '0;
            end else if (hit) begin
                vld <= 1'b1;
                msk <= '0;
            end else begin
                if (kill || (ok_valid && ok_id == CW'(j))) vld <= 1'b0;
                if (vld) msk <= msk | alloc_bits;
            end
        end

        always_ff @(posedge clk) begin
            if (hit) snp <= snap_in;
        end

        assign vld_w[j] = vld;
        assign msk_w[j] = msk;
        assign snp_w[j] = snp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         tail_q <= '0;
        else if (bad_valid) tail_q <= bad_id;
        else if (take)      tail_q <= tail_q + 1'b1;
    end

    assign tail      = tail_q;
    assign full      = vld_w[tail_q];
    assign back_map  = snp_w[bad_id];
    assign back_mask = msk_w[bad_id];
endmodule

// File: rtl/rn_rename_unit.sv
module rn_rename_unit #(
    parameter int NARCH = 32,
    parameter int NPHYS = 64,
    parameter int NCKPT = 4,
    localparam int AW = $clog2(NARCH),
    localparam int PW = $clog2(NPHYS),
    localparam int CW = $clog2(NCKPT),
    localparam int MW = NARCH * PW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      rn_valid,
    input  logic [2*AW-1:0] rn_src_a,
    input  logic [2*AW-1:0] rn_src_b,
    input  logic [1:0]      rn_dst_en,
    input  logic [2*AW-1:0] rn_dst,
    input  logic            rn_ckpt,
    output logic            rn_ready,
    output logic [2*PW-1:0] rn_ps_a,
    output logic [2*PW-1:0] rn_ps_b,
    output logic [2*PW-1:0] rn_pd,
    output logic [2*PW-1:0] rn_pold,
    output logic [CW-1:0]   rn_tag,
    input  logic            cm_valid,
    input  logic [PW-1:0]   cm_preg,
    input  logic            br_ok_valid,
    input  logic [CW-1:0]   br_ok_id,
    input  logic            br_bad_valid,
    input  logic [CW-1:0]   br_bad_id
);
    import rn_pkg::*;

    rn_state_e state_q, state_d;

    logic [AW-1:0]    sa0, sa1, sb0, sb1, d0, d1;
    logic             alloc0, alloc1, fire, room, ck_block, take0, take1;
    logic [1:0]       need;
    logic [PW-1:0]    pick0, pick1, pd0, pd1;
    logic [PW:0]      free_cnt;
    logic [NPHYS-1:0] alloc_bits, back_mask;
    logic [MW-1:0]    map_cur, map_nxt, back_map;
    logic             ck_full;

    function automatic logic [PW-1:0] lk(input logic [MW-1:0] m, input logic [AW-1:0] a);
        return m[a*PW +: PW];
    endfunction

    assign sa0 = rn_src_a[AW-1:0];
    assign sa1 = rn_src_a[2*AW-1:AW];
    assign sb0 = rn_src_b[AW-1:0];
    assign sb1 = rn_src_b[2*AW-1:AW];
    assign d0  = rn_dst[AW-1:0];
    assign d1  = rn_dst[2*AW-1:AW];

    assign alloc0   = rn_valid[0] & rn_dst_en[0];
    assign alloc1   = rn_valid[1] & rn_dst_en[1];
    assign need     = {1'b0, alloc0} + {1'b0, alloc1};
    assign room     = free_cnt >= (PW+1)'(need);
    assign ck_block = rn_ckpt && ck_full;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // next state and acceptance
    always_comb begin
        state_d  = state_q;
        rn_ready = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                rn_ready = !br_bad_valid && room && !ck_block;
                if (br_bad_valid) state_d = ST_RECOVER;
            end
            ST_RECOVER: begin
                rn_ready = 1'b0;
                state_d  = br_bad_valid ? ST_RECOVER : ST_RUN;
            end
        endcase
    end

    assign fire  = rn_ready && (rn_valid != 2'b00);
    assign take0 = fire && (alloc0 || alloc1);
    assign take1 = fire && alloc0 && alloc1;
    assign pd0   = pick0;
    assign pd1   = alloc0 ? pick1 : pick0;

    always_comb begin
        rn_ps_a[PW-1:0]    = lk(map_cur, sa0);
        rn_ps_b[PW-1:0]    = lk(map_cur, sb0);
        rn_pold[PW-1:0]    = lk(map_cur, d0);
        rn_ps_a[2*PW-1:PW] = (alloc0 && sa1 == d0) ? pd0 : lk(map_cur, sa1);
        rn_ps_b[2*PW-1:PW] = (alloc0 && sb1 == d0) ? pd0 : lk(map_cur, sb1);
        rn_pold[2*PW-1:PW] = (alloc0 && d1 == d0)  ? pd0 : lk(map_cur, d1);
        rn_pd              = {pd1, pd0};
    end

    rn_freelist #(.NARCH(NARCH), .NPHYS(NPHYS)) u_free (
        .clk(clk), .rst_n(rst_n), .take0(take0), .take1(take1),
        .rel_valid(cm_valid), .rel_reg(cm_preg),
        .restore(br_bad_valid), .restore_mask(back_mask),
        .pick0(pick0), .pick1(pick1), .free_cnt(free_cnt), .alloc_bits(alloc_bits)
    );

    rn_map #(.NARCH(NARCH), .NPHYS(NPHYS)) u_map (
        .clk(clk), .rst_n(rst_n),
        .we0(fire && alloc0), .wa0(d0), .wd0(pd0),
        .we1(fire && alloc1), .wa1(d1), .wd1(pd1),
        .restore(br_bad_valid), .restore_map(back_map),
        .map_cur(map_cur), .map_nxt(map_nxt)
    );

    rn_ckpt #(.NARCH(NARCH), .NPHYS(NPHYS), .NCKPT(NCKPT)) u_ckpt (
        .clk(clk), .rst_n(rst_n), .take(fire && rn_ckpt), .snap_in(map_nxt),
        .alloc_bits(alloc_bits),
        .ok_valid(br_ok_valid), .ok_id(br_ok_id),
        .bad_valid(br_bad_valid), .bad_id(br_bad_id),
        .full(ck_full), .tail(rn_tag), .back_map(back_map), .back_mask(back_mask)
    );
endmodule

// File: rtl/rn_rename_unit_chk.sv
module rn_rename_unit_chk #(
    parameter int NARCH = 32,
    parameter int NPHYS = 64,
    parameter int NCKPT = 4,
    localparam int AW = $clog2(NARCH),
    localparam int PW = $clog2(NPHYS),
    localparam int CW = $clog2(NCKPT)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      rn_valid,
    input logic [1:0]      rn_dst_en,
    input logic            rn_ckpt,
    input logic            rn_ready,
    input logic [2*PW-1:0] rn_pd,
    input logic [2*PW-1:0] rn_pold,
    input logic [CW-1:0]   rn_tag,
    input logic            br_bad_valid
);
    logic acc;
    assign acc = rn_ready && (rn_valid != 2'b00);

    // R3
    new_reg_differs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && rn_valid[0] && rn_dst_en[0]) |-> (rn_pd[PW-1:0] != rn_pold[PW-1:0]));

    // R4
    pair_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (rn_valid & rn_dst_en) == 2'b11) |-> (rn_pd[PW-1:0] != rn_pd[2*PW-1:PW]));

    // R10
    recover_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_bad_valid |=> !rn_ready);

    // R7
    tag_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && rn_ckpt) ##1 (acc && rn_ckpt) |-> (rn_tag == CW'($past(rn_tag) + 1'b1)));
endmodule

bind rn_rename_unit rn_rename_unit_chk #(.NARCH(NARCH), .NPHYS(NPHYS), .NCKPT(NCKPT)) u_chk (
    .clk(clk), .rst_n(rst_n), .rn_valid(rn_valid), .rn_dst_en(rn_dst_en),
    .rn_ckpt(rn_ckpt), .rn_ready(rn_ready), .rn_pd(rn_pd), .rn_pold(rn_pold),
    .rn_tag(rn_tag), .br_bad_valid(br_bad_valid)
);

// File: tb/tb_rn_rename_unit.sv
`timescale 1ns/1ps
module tb_rn_rename_unit;
    localparam int NA = 32, NP = 64, NC = 4;
    localparam int AW = 5, PW = 6, CW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [1:0]    v = '0, en = '0;
    logic [AW-1:0] sa0 = '0, sa1 = '0, sb0 = '0, sb1 = '0, d0 = '0, d1 = '0;
    logic          ck = 1'b0, cmv = 1'b0, okv = 1'b0, badv = 1'b0;
    logic [PW-1:0] cmr = '0;
    logic [CW-1:0] oki = '0, bi = '0;

    logic            rn_ready;
    logic [2*PW-1:0] rn_ps_a, rn_ps_b, rn_pd, rn_pold;
    logic [CW-1:0]   rn_tag;

    rn_rename_unit dut (
        .clk(clk), .rst_n(rst_n), .rn_valid(v), .rn_src_a({sa1, sa0}), .rn_src_b({sb1, sb0}),
        .rn_dst_en(en), .rn_dst({d1, d0}), .rn_ckpt(ck), .rn_ready(rn_ready),
        .rn_ps_a(rn_ps_a), .rn_ps_b(rn_ps_b), .rn_pd(rn_pd), .rn_pold(rn_pold), .rn_tag(rn_tag),
        .cm_valid(cmv), .cm_preg(cmr), .br_ok_valid(okv), .br_ok_id(oki),
        .br_bad_valid(badv), .br_bad_id(bi)
    );

    typedef struct {
        bit rdy; bit [1:0] v; bit [1:0] en; bit ck;
        int psa0, psb0, pd0, po0, psa1, psb1, pd1, po1, tag;
        string rq;
    } exp_t;
    exp_t q[$];

    int total = 0, bad = 0;

    // requirement model
    int mp[NA];
    bit fr[NP];
    bit cv[NC];
    int cmap[NC][NA];
    bit cmask[NC][NP];
    int tl;
    bit rec;

    task automatic model_reset();
        for (int i = 0; i < NA; i++) mp[i] = i;
        for (int i = 0; i < NP; i++) fr[i] = (i >= NA);
        for (int c = 0; c < NC; c++) cv[c] = 0;
        tl = 0;
        rec = 0;
    endtask

    task automatic step(input string rq);
        exp_t e;
        int p0, p1, cnt, need, pd0, pd1;
        bit a0, a1;
        p0 = -1; p1 = -1; cnt = 0;
        for (int i = 0; i < NP; i++) if (fr[i]) begin
            cnt++;
            if (p0 < 0) p0 = i; else if (p1 < 0) p1 = i;
        end
        a0 = v[0] & en[0];
        a1 = v[1] & en[1];
        need = int'(a0) + int'(a1);
        e.rq = rq; e.v = v; e.en = en; e.ck = ck;
        e.rdy = !rec && !badv && (cnt >= need) && !(ck && cv[tl]);
        if (e.rdy && v != 0) begin
            pd0 = p0;
            pd1 = a0 ? p1 : p0;
            e.psa0 = mp[sa0]; e.psb0 = mp[sb0]; e.po0 = mp[d0]; e.pd0 = pd0;
            e.psa1 = (a0 && sa1 == d0) ? pd0 : mp[sa1];
            e.psb1 = (a0 && sb1 == d0) ? pd0 : mp[sb1];
            e.po1  = (a0 && d1 == d0) ? pd0 : mp[d1];
            e.pd1  = pd1;
            if (a0) begin
                mp[d0] = pd0; fr[pd0] = 0;
                for (int c = 0; c < NC; c++) if (cv[c]) cmask[c][pd0] = 1;
            end
            if (a1) begin
                mp[d1] = pd1; fr[pd1] = 0;
                for (int c = 0; c < NC; c++) if (cv[c]) cmask[c][pd1] = 1;
            end
            if (ck) begin
                e.tag = tl;
                cv[tl] = 1;
                cmap[tl] = mp;
                for (int i = 0; i < NP; i++) cmask[tl][i] = 0;
                tl = (tl + 1) % NC;
            end
        end
        if (cmv) fr[cmr] = 1;
        if (okv) cv[oki] = 0;
        if (badv) begin
            int dt;
            mp = cmap[bi];
            for (int i = 0; i < NP; i++) if (cmask[bi][i]) fr[i] = 1;
            dt = (tl - int'(bi) + NC) % NC;
            for (int j = 0; j < NC; j++) begin
                int dj;
                dj = (j - int'(bi) + NC) % NC;
                if (dt == 0 || dj < dt) cv[j] = 0;
            end
            tl = bi;
            rec = 1;
        end else begin
            rec = 0;
        end
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // monitor: compares outputs 1 ns after each drive point
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(rn_ready == e.rdy, e.rq, "ready", int'(rn_ready), int'(e.rdy));
                if (e.rdy && e.v[0]) begin
                    chk(int'(rn_ps_a[PW-1:0]) == e.psa0, e.rq, "ps_a0", int'(rn_ps_a[PW-1:0]), e.psa0);
                    chk(int'(rn_ps_b[PW-1:0]) == e.psb0, e.rq, "ps_b0", int'(rn_ps_b[PW-1:0]), e.psb0);
                    if (e.en[0]) begin
                        chk(int'(rn_pd[PW-1:0]) == e.pd0, e.rq, "pd0", int'(rn_pd[PW-1:0]), e.pd0);
                        chk(int'(rn_pold[PW-1:0]) == e.po0, e.rq, "pold0", int'(rn_pold[PW-1:0]), e.po0);
                    end
                end
                if (e.rdy && e.v[1]) begin
                    chk(int'(rn_ps_a[2*PW-1:PW]) == e.psa1, e.rq, "ps_a1", int'(rn_ps_a[2*PW-1:PW]), e.psa1);
                    chk(int'(rn_ps_b[2*PW-1:PW]) == e.psb1, e.rq, "ps_b1", int'(rn_ps_b[2*PW-1:PW]), e.psb1);
                    if (e.en[1]) begin
                        chk(int'(rn_pd[2*PW-1:PW]) == e.pd1, e.rq, "pd1", int'(rn_pd[2*PW-1:PW]), e.pd1);
                        chk(int'(rn_pold[2*PW-1:PW]) == e.po1, e.rq, "pold1", int'(rn_pold[2*PW-1:PW]), e.po1);
                    end
                end
                if (e.rdy && e.v != 0 && e.ck)
                    chk(int'(rn_tag) == e.tag, e.rq, "tag", int'(rn_tag), e.tag);
            end
        end
    end

    task automatic idle();
        v = 0; en = 0; ck = 0; cmv = 0; okv = 0; badv = 0;
    endtask

    task automatic one(input int a, input int b, input bit w, input int d, input bit c, input string rq);
        idle();
        v = 2'b01; sa0 = AW'(a); sb0 = AW'(b); en = {1'b0, w}; d0 = AW'(d); ck = c;
        step(rq);
    endtask

    task automatic two(input int a0, input int b0, input int dd0, input int a1, input int b1,
                       input int dd1, input string rq);
        idle();
        v = 2'b11; en = 2'b11;
        sa0 = AW'(a0); sb0 = AW'(b0); d0 = AW'(dd0);
        sa1 = AW'(a1); sb1 = AW'(b1); d1 = AW'(dd1);
        step(rq);
    endtask

    task automatic commit(input int r, input string rq);
        idle(); cmv = 1; cmr = PW'(r); step(rq);
    endtask

    task automatic mispredict(input int k, input string rq);
        idle(); badv = 1; bi = CW'(k); step(rq);
    endtask

    task automatic resolve(input int k, input string rq);
        idle(); okv = 1; oki = CW'(k); step(rq);
    endtask

    initial begin
        #800000;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 identity map and reset free set
        idle(); step("R1");
        one(5, 31, 1, 3, 0, "R1");
        // R2 newest mapping of a renamed register
        one(3, 0, 1, 9, 0, "R2");
        // R3 lowest free register and previous mapping
        one(9, 3, 1, 3, 0, "R3");
        // R4 same-cycle bypass and same destination
        two(1, 2, 7, 7, 3, 7, "R4");
        two(4, 4, 10, 10, 10, 11, "R4");
        // R5 a committed register is reallocated first
        commit(3, "R5");
        one(0, 0, 1, 12, 0, "R5");
        // R7/R8/R9/R10 checkpoint, younger work, commit, mispredict
        one(7, 11, 0, 0, 1, "R7");
        two(7, 12, 7, 7, 1, 13, "R9");
        commit(2, "R9");
        one(13, 7, 1, 14, 0, "R9");
        mispredict(0, "R10");
        one(7, 13, 1, 20, 0, "R10");
        one(7, 13, 1, 20, 0, "R8");
        one(12, 14, 1, 21, 0, "R9");
        two(0, 0, 22, 0, 0, 23, "R9");
        // R7 fill all slots, fifth is refused
        one(1, 1, 0, 0, 1, "R7");
        one(2, 2, 0, 0, 1, "R7");
        one(3, 3, 1, 4, 1, "R7");
        one(4, 4, 0, 0, 1, "R7");
        one(5, 5, 1, 6, 1, "R7");
        // R12 release the oldest and reuse its slot
        resolve(0, "R12");
        one(5, 5, 1, 6, 1, "R12");
        one(6, 6, 1, 8, 1, "R7");
        // R11 mispredict in the middle of a wrapped ring
        one(8, 8, 1, 15, 0, "R11");
        mispredict(2, "R11");
        idle(); step("R10");
        one(4, 6, 0, 0, 1, "R11");
        one(8, 15, 1, 16, 1, "R11");
        one(16, 15, 0, 0, 1, "R11");
        mispredict(1, "R11");
        idle(); step("R10");
        one(16, 8, 1, 17, 1, "R8");
        resolve(1, "R12");
        resolve(0, "R12");
        // R6 drain the free vector then recover by commit
        for (int i = 0; i < 40; i++) one(i % NA, 1, 1, i % NA, 0, "R6");
        two(1, 2, 3, 4, 5, 6, "R6");
        commit(5, "R5");
        two(1, 2, 3, 4, 5, 6, "R6");
        one(1, 2, 1, 3, 0, "R6");
        commit(6, "R5");
        commit(7, "R5");
        two(0, 3, 3, 3, 3, 4, "R4");
        idle();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule